// File: doc/BRIEF.md
# Packet Error Rate Test Sequencer

This block drives the built-in link-quality test of a packet radio baseband. In transmit it resends the buffered packet a programmed number of times and waits a set interpacket gap before each resend. In receive it counts the packets that pass CRC and re-arms the receiver after each one. Comparing the receive count with the number sent gives the packet error rate of the link.

Software reaches the block through a byte-wide register port. The registers are a mode register, the two halves of a 16-bit packet counter and a wait-time byte. Software starts a run with a one-cycle transmit or receive command. The packet engine reports end-of-frame and CRC-good events as one-cycle pulses. In return the block issues one-cycle start-transmit, start-receive and interrupt-clear strobes. All gap lengths are counted in system clock cycles and set by parameters, so the timing can be checked exactly.

Top module: `per_test_seq`

## Requirements
- R1: The mode register is at address 0 and reads back as {4'b0, mode}. Mode bit 3 selects automatic interrupt clear, bit 2 enables the test, bit 1 selects continuous transmit and bit 0 selects continuous receive. After reset every register reads 0 and every strobe output is low.
- R2: The counter low byte (bits [7:0]) is at address 1, the counter high byte (bits [15:8]) at address 2 and the wait byte at address 3. These three locations take writes and return data only while the enable bit is set. While it is clear they read 0x00 and writes to them are dropped.
- R3: In receive, each crc_ok_i pulse adds one to the counter, wrapping from 0xFFFF to 0x0000. If bit 3 is set, crc_irq_clr_o pulses in the cycle after the event.
- R4: After a CRC-good event, rx_start_o pulses in the next cycle when bit 0 is set. When bit 0 is clear the sequencer goes idle, and later crc_ok_i pulses leave the counter unchanged.
- R5: In transmit, each tx_eof_i pulse lowers a nonzero counter by one. If bit 3 is set, tx_irq_clr_o pulses in the cycle after the event.
- R6: A continuous transmit run started with counter value N sends N+1 packets. The last end-of-frame event clears mode bit 1 and leaves the counter at 0.
- R7: With wait byte W nonzero, tx_start_o rises BASE_CYC + W*STEP cycles after the end-of-frame edge. STEP is STEP_FAST_CYC when fast_trans_i is 1 and STEP_SLOW_CYC when it is 0.
- R8: With W equal to 0, the gap is DEF_FAST_CYC cycles when fast_trans_i is 1 and DEF_SLOW_CYC cycles when it is 0.
- R9: With the enable bit set and the sequencer idle, a go_tx_i or go_rx_i pulse gives a tx_start_o or rx_start_o pulse in the next cycle. With the enable bit clear, the command is ignored.
- R10: Clearing the enable bit during a run sends the sequencer to idle. No further start strobe follows, and the counter keeps its value.
- R11: A transmit run started with a counter of 0 sends exactly one packet and then clears mode bit 1.
- R12: Starting a run does not reset the counter. A receive run counts on from whatever value the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| reg_raddr_i | input | 2 | Register read address |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| fast_trans_i | input | 1 | Fast-transition timing select |
| go_tx_i | input | 1 | Software command to start a transmit run |
| go_rx_i | input | 1 | Software command to start a receive run |
| tx_eof_i | input | 1 | End-of-frame pulse from the packet engine |
| crc_ok_i | input | 1 | CRC-good pulse from the packet engine |
| tx_start_o | output | 1 | Start-transmit strobe |
| rx_start_o | output | 1 | Start-receive strobe |
| tx_irq_clr_o | output | 1 | End-of-frame interrupt clear strobe |
| crc_irq_clr_o | output | 1 | CRC interrupt clear strobe |

## Verification
Every strobe is registered, so it is due exactly one clock after the edge that samples its command or event. The counter and mode updates can be read back at that same time. The bench drives inputs on falling edges and reads results on the next falling edge, which is the first point at which a one-cycle-late result is visible. Gap lengths are measured by counting rising edges from the edge that sampled tx_eof_i to the first falling edge that shows tx_start_o high. Each count is compared with BASE_CYC + W*STEP or with the default gap, worked out from the bench's own small parameter values.

// File: rtl/per_pkg.sv
package per_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLO  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 2'd2;
  localparam logic [ADDR_W-1:0] A_WAIT = 2'd3;

  localparam int unsigned B_SELFCLR = 3;
  localparam int unsigned B_EN      = 2;
  localparam int unsigned B_CTX     = 1;
  localparam int unsigned B_CRX     = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_GAP  = 2'd2,
    ST_RX   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/per_regs.sv
module per_regs
  import per_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  input  logic              cnt_inc_i,
  input  logic              cnt_dec_i,
  input  logic              clr_ctx_i,
  output logic [3:0]        mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        wait_o
);
  logic [3:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       wait_q;
  logic             en, mode_wr, lo_wr, hi_wr, cnt_wr;

  assign en      = mode_q[B_EN];
  assign mode_wr = we_i && (addr_i == A_MODE);
  assign lo_wr   = we_i && en && (addr_i == A_CLO);
  assign hi_wr   = we_i && en && (addr_i == A_CHI);
  assign cnt_wr  = lo_wr || hi_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= wdata_i[3:0];
    end else if (clr_ctx_i) begin
      mode_q[B_CTX] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (lo_wr) begin
      cnt_q[7:0] <= wdata_i;
    end else if (hi_wr) begin
      cnt_q[15:8] <= wdata_i;
    end else if (cnt_inc_i) begin
      cnt_q <= cnt_q + 16'd1;
    end else if (cnt_dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 16'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (we_i && en && (addr_i == A_WAIT)) begin
      wait_q <= wdata_i;
    end
  end

  // counter and wait byte are only mapped while the test is enabled
  always_comb begin
    rdata_o = 8'h00;
    case (raddr_i)
      A_MODE:  rdata_o = {4'b0000, mode_q};
      A_CLO:   rdata_o = en ? cnt_q[7:0]  : 8'h00;
      A_CHI:   rdata_o = en ? cnt_q[15:8] : 8'h00;
      default: rdata_o = en ? wait_q      : 8'h00;
    endcase
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
  assign wait_o = wait_q;

  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_inc_i && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 16'd1));
  // R5
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && !cnt_inc_i && !cnt_wr && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 16'd1));
  // R6
  ctx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ctx_i && !mode_wr) |=> !mode_q[B_CTX]);
endmodule

// File: rtl/per_gap_timer.sv
module per_gap_timer #(
  parameter int unsigned BASE_CYC      = 5000,
  parameter int unsigned STEP_FAST_CYC = 125,
  parameter int unsigned STEP_SLOW_CYC = 500,
  parameter int unsigned DEF_FAST_CYC  = 140000,
  parameter int unsigned DEF_SLOW_CYC  = 520000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       abort_i,
  input  logic [7:0] wait_i,
  input  logic       fast_i,
  output logic       expire_o
);
  localparam int unsigned NZ_MAX  = BASE_CYC + 255 * STEP_SLOW_CYC;
  localparam int unsigned DEF_MAX = (DEF_SLOW_CYC > DEF_FAST_CYC) ? DEF_SLOW_CYC : DEF_FAST_CYC;
  localparam int unsigned GAP_MAX = (NZ_MAX > DEF_MAX) ? NZ_MAX : DEF_MAX;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] step_c, gap_len, cnt_q;
  logic             run_q;

  always_comb begin
    step_c = fast_i ? GAP_W'(STEP_FAST_CYC) : GAP_W'(STEP_SLOW_CYC);
    if (wait_i == 8'd0) begin
      gap_len = fast_i ? GAP_W'(DEF_FAST_CYC) : GAP_W'(DEF_SLOW_CYC);
    end else begin
      gap_len = GAP_W'(BASE_CYC) + ({{(GAP_W-8){1'b0}}, wait_i} * step_c);
    end
  end

  // loaded with gap-1 so expiry lands gap cycles after the load edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= gap_len - GAP_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - GAP_W'(1);
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

  // R7
  gap_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (gap_len != '0));
endmodule

// File: rtl/per_seq_fsm.sv
module per_seq_fsm
  import per_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic selfclr_i,
  input  logic cont_tx_i,
  input  logic cont_rx_i,
  input  logic cnt_zero_i,
  input  logic go_tx_i,
  input  logic go_rx_i,
  input  logic tx_eof_i,
  input  logic crc_ok_i,
  input  logic gap_expire_i,
  output logic cnt_inc_o,
  output logic cnt_dec_o,
  output logic clr_ctx_o,
  output logic gap_load_o,
  output logic gap_abort_o,
  output logic tx_start_o,
  output logic rx_start_o,
  output logic tx_irq_clr_o,
  output logic crc_irq_clr_o
);
  seq_state_e state_q, state_d;
  logic tx_go, rx_go, tx_clr, rx_clr;

  always_comb begin
    state_d     = state_q;
    tx_go       = 1'b0;
    rx_go       = 1'b0;
    tx_clr      = 1'b0;
    rx_clr      = 1'b0;
    cnt_inc_o   = 1'b0;
    cnt_dec_o   = 1'b0;
    clr_ctx_o   = 1'b0;
    gap_load_o  = 1'b0;
    gap_abort_o = 1'b0;
    if (!en_i) begin
      state_d     = ST_IDLE;
      gap_abort_o = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_tx_i) begin
            tx_go   = 1'b1;
            state_d = ST_TX;
          end else if (go_rx_i) begin
            rx_go   = 1'b1;
            state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (tx_eof_i) begin
            cnt_dec_o = 1'b1;
            tx_clr    = selfclr_i;
            if (cnt_zero_i) begin
              clr_ctx_o = 1'b1;
              state_d   = ST_IDLE;
            end else if (cont_tx_i) begin
              gap_load_o = 1'b1;
              state_d    = ST_GAP;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (gap_expire_i) begin
            tx_go   = 1'b1;
            state_d = ST_TX;
          end
        end
        default: begin
          if (crc_ok_i) begin
            cnt_inc_o = 1'b1;
            rx_clr    = selfclr_i;
            if (cont_rx_i) rx_go = 1'b1;
            else           state_d = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      tx_start_o    <= 1'b0;
      rx_start_o    <= 1'b0;
      tx_irq_clr_o  <= 1'b0;
      crc_irq_clr_o <= 1'b0;
    end else begin
      state_q       <= state_d;
      tx_start_o    <= tx_go;
      rx_start_o    <= rx_go;
      tx_irq_clr_o  <= tx_clr;
      crc_irq_clr_o <= rx_clr;
    end
  end

  // R9
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o || rx_start_o) |-> $past(en_i));
  // R9
  no_dual_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_start_o && rx_start_o));
  // R3
  irq_clr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_irq_clr_o || crc_irq_clr_o) |-> $past(selfclr_i));
  // R10
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/per_test_seq.sv
module per_test_seq
  import per_pkg::*;
#(
  parameter int unsigned BASE_CYC      = 5000,
  parameter int unsigned STEP_FAST_CYC = 125,
  parameter int unsigned STEP_SLOW_CYC = 500,
  parameter int unsigned DEF_FAST_CYC  = 140000,
  parameter int unsigned DEF_SLOW_CYC  = 520000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic [1:0] reg_raddr_i,
  output logic [7:0] reg_rdata_o,
  input  logic       fast_trans_i,
  input  logic       go_tx_i,
  input  logic       go_rx_i,
  input  logic       tx_eof_i,
  input  logic       crc_ok_i,
  output logic       tx_start_o,
  output logic       rx_start_o,
  output logic       tx_irq_clr_o,
  output logic       crc_irq_clr_o
);
  logic [3:0]       mode;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       wait_b;
  logic cnt_inc, cnt_dec, clr_ctx, gap_load, gap_abort, gap_expire;

  per_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .raddr_i   (reg_raddr_i),
    .rdata_o   (reg_rdata_o),
    .cnt_inc_i (cnt_inc),
    .cnt_dec_i (cnt_dec),
    .clr_ctx_i (clr_ctx),
    .mode_o    (mode),
    .cnt_o     (cnt),
    .wait_o    (wait_b)
  );

  per_gap_timer #(
    .BASE_CYC      (BASE_CYC),
    .STEP_FAST_CYC (STEP_FAST_CYC),
    .STEP_SLOW_CYC (STEP_SLOW_CYC),
    .DEF_FAST_CYC  (DEF_FAST_CYC),
    .DEF_SLOW_CYC  (DEF_SLOW_CYC)
  ) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (gap_load),
    .abort_i  (gap_abort),
    .wait_i   (wait_b),
    .fast_i   (fast_trans_i),
    .expire_o (gap_expire)
  );

  per_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (mode[B_EN]),
    .selfclr_i     (mode[B_SELFCLR]),
    .cont_tx_i     (mode[B_CTX]),
    .cont_rx_i     (mode[B_CRX]),
    .cnt_zero_i    (cnt == '0),
    .go_tx_i       (go_tx_i),
    .go_rx_i       (go_rx_i),
    .tx_eof_i      (tx_eof_i),
    .crc_ok_i      (crc_ok_i),
    .gap_expire_i  (gap_expire),
    .cnt_inc_o     (cnt_inc),
    .cnt_dec_o     (cnt_dec),
    .clr_ctx_o     (clr_ctx),
    .gap_load_o    (gap_load),
    .gap_abort_o   (gap_abort),
    .tx_start_o    (tx_start_o),
    .rx_start_o    (rx_start_o),
    .tx_irq_clr_o  (tx_irq_clr_o),
    .crc_irq_clr_o (crc_irq_clr_o)
  );
endmodule

// File: tb/tb_per_test_seq.sv
module tb_per_test_seq;
  localparam int unsigned T_BASE = 5;
  localparam int unsigned T_SF   = 3;
  localparam int unsigned T_SS   = 12;
  localparam int unsigned T_DF   = 40;
  localparam int unsigned T_DS   = 150;

  // {fast, wait byte, expected gap cycles}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 8'd1,   12'd8},
    {1'b0, 8'd1,   12'd17},
    {1'b1, 8'd10,  12'd35},
    {1'b0, 8'd10,  12'd125},
    {1'b1, 8'd0,   12'd40},
    {1'b0, 8'd0,   12'd150},
    {1'b1, 8'd255, 12'd770},
    {1'b0, 8'd255, 12'd3065}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, fast = 1'b0, go_tx = 1'b0, go_rx = 1'b0, eof = 1'b0, crc = 1'b0;
  logic [1:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0, rdata;
  logic tx_start, rx_start, tx_clr, crc_clr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  per_test_seq #(
    .BASE_CYC(T_BASE), .STEP_FAST_CYC(T_SF), .STEP_SLOW_CYC(T_SS),
    .DEF_FAST_CYC(T_DF), .DEF_SLOW_CYC(T_DS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata), .fast_trans_i(fast), .go_tx_i(go_tx),
    .go_rx_i(go_rx), .tx_eof_i(eof), .crc_ok_i(crc), .tx_start_o(tx_start),
    .rx_start_o(rx_start), .tx_irq_clr_o(tx_clr), .crc_irq_clr_o(crc_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    raddr = a; #1; d = rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(2'd1, lo); rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input int v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  // each pulse task leaves time at the falling edge after the sampling edge
  task automatic pulse_go_tx();
    @(negedge clk); go_tx = 1'b1; @(negedge clk); go_tx = 1'b0;
  endtask
  task automatic pulse_go_rx();
    @(negedge clk); go_rx = 1'b1; @(negedge clk); go_rx = 1'b0;
  endtask
  task automatic pulse_eof();
    @(negedge clk); eof = 1'b1; @(negedge clk); eof = 1'b0;
  endtask
  task automatic pulse_crc();
    @(negedge clk); crc = 1'b1; @(negedge clk); crc = 1'b0;
  endtask

  // rising edges from now until tx_start is seen high, 0 if none within lim
  task automatic wait_start(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (tx_start) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int v, n, pk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d);
    chk(d == 8'h00, "R1 mode reset", d, 0);
    chk({tx_start, rx_start, tx_clr, crc_clr} == 4'b0, "R1 strobes reset",
        {tx_start, rx_start, tx_clr, crc_clr}, 0);
    wr(2'd0, 8'h0B);
    rd(2'd0, d);
    chk(d == 8'h0B, "R1 mode readback", d, 8'h0B);

    // R2 disabled mapping: writes dropped, reads zero
    wr(2'd0, 8'h04); set_cnt(16'h1234);
    wr(2'd0, 8'h00); wr(2'd1, 8'h55); wr(2'd3, 8'h77);
    rd(2'd1, d);
    chk(d == 8'h00, "R2 disabled read", d, 0);
    wr(2'd0, 8'h04);
    rd_cnt(v);
    chk(v == 16'h1234, "R2 disabled write dropped", v, 16'h1234);
    rd(2'd3, d);
    chk(d == 8'h00, "R2 wait write dropped", d, 0);

    // R9 command ignored while disabled
    wr(2'd0, 8'h0E - 8'h04);
    pulse_go_tx();
    wait_start(20, n);
    chk(n == 0, "R9 go while disabled", n, 0);

    // R7 R8 gap vectors
    foreach (VEC[k]) begin
      wr(2'd0, 8'h04);
      wr(2'd3, VEC[k][19:12]);
      set_cnt(1);
      wr(2'd0, 8'h0E);
      fast = VEC[k][20];
      pulse_go_tx();
      chk(tx_start == 1'b1, "R9 tx start after go", tx_start, 1);
      pulse_eof();
      chk(tx_clr == 1'b1, "R5 tx irq clear", tx_clr, 1);
      wait_start(4000, n);
      chk(n == int'(VEC[k][11:0]), (VEC[k][19:12] == 0) ? "R8 default gap" : "R7 gap length",
          n, int'(VEC[k][11:0]));
      pulse_eof();
    end

    // R6 counter 2 gives three packets
    wr(2'd0, 8'h04); wr(2'd3, 8'd1); fast = 1'b1;
    set_cnt(2); wr(2'd0, 8'h0E);
    pulse_go_tx(); pk = 1;
    for (int i = 0; i < 10; i++) begin
      pulse_eof();
      wait_start(50, n);
      if (n == 0) break;
      pk++;
    end
    chk(pk == 3, "R6 packets sent", pk, 3);
    rd(2'd0, d);
    chk(d == 8'h0C, "R6 continuous bit cleared", d, 8'h0C);
    rd_cnt(v);
    chk(v == 0, "R6 final counter", v, 0);

    // R11 zero counter gives one packet
    wr(2'd0, 8'h0E);
    pulse_go_tx(); pk = 1;
    pulse_eof();
    wait_start(50, n);
    if (n != 0) pk++;
    chk(pk == 1, "R11 single packet", pk, 1);
    rd(2'd0, d);
    chk(d == 8'h0C, "R11 continuous bit cleared", d, 8'h0C);

    // R5 decrement without self clear, non-continuous
    wr(2'd0, 8'h04); set_cnt(7);
    pulse_go_tx();
    pulse_eof();
    chk(tx_clr == 1'b0, "R5 no irq clear without bit 3", tx_clr, 0);
    rd_cnt(v);
    chk(v == 6, "R5 decrement", v, 6);

    // R10 disable during a gap
    wr(2'd3, 8'd255); fast = 1'b0; set_cnt(5); wr(2'd0, 8'h0E);
    pulse_go_tx();
    pulse_eof();
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h0A);
    wait_start(3500, n);
    chk(n == 0, "R10 no start after disable", n, 0);
    wr(2'd0, 8'h04);
    rd_cnt(v);
    chk(v == 4, "R10 counter kept", v, 4);

    // R3 R4 continuous receive
    set_cnt(0); wr(2'd0, 8'h0D);
    pulse_go_rx();
    chk(rx_start == 1'b1, "R9 rx start after go", rx_start, 1);
    for (int i = 1; i <= 3; i++) begin
      pulse_crc();
      chk(rx_start == 1'b1, "R4 rx restart", rx_start, 1);
      chk(crc_clr == 1'b1, "R3 crc irq clear", crc_clr, 1);
      rd_cnt(v);
      chk(v == i, "R3 count up", v, i);
    end

    // R12 counter not reset by a new run
    wr(2'd0, 8'h04); wr(2'd0, 8'h0D);
    pulse_go_rx();
    pulse_crc();
    rd_cnt(v);
    chk(v == 4, "R12 count continues", v, 4);

    // R3 wrap
    wr(2'd0, 8'h04); set_cnt(16'hFFFF); wr(2'd0, 8'h0D);
    pulse_go_rx();
    pulse_crc();
    rd_cnt(v);
    chk(v == 0, "R3 wrap", v, 0);

    // R4 single receive: no restart, later events ignored
    wr(2'd0, 8'h04); set_cnt(10); wr(2'd0, 8'h04);
    pulse_go_rx();
    pulse_crc();
    chk(rx_start == 1'b0, "R4 no restart", rx_start, 0);
    chk(crc_clr == 1'b0, "R3 no crc clear without bit 3", crc_clr, 0);
    pulse_crc();
    rd_cnt(v);
    chk(v == 11, "R4 idle ignores crc", v, 11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule